// File: doc/BRIEF.md
# Dual-Read General-Purpose Register File with Protected Register Zero

This block holds eight 32-bit general-purpose registers for a datapath that has two operand buses and one result bus. On each cycle, any register can be presented on operand bus A, on operand bus B, or on both. A result can be written into any register except register 0, which always holds zero.

Reads are combinational. Each read port is an 8-to-1 selection gated by that port's own enable. Writes pass through an enabled one-hot decoder, and the selected register captures the result data at the next rising clock edge. Decoder output 0 drives nothing. A write aimed at register 0 is therefore dropped, and the register keeps its reset value of zero.

The control logic that derives the selectors from instruction fields sits outside this block.

Top module: `regfile_dual_read`

## Requirements
- R1: After reset, every register reads as zero on both read ports.
- R2: A write with `wr_sel` = 0 has no effect. Register 0 always reads as zero.
- R3: A write changes only the register selected by `wr_sel`. The internal write strobes are at most one-hot.
- R4: While `wr_en` is low, no register changes, whatever values `wr_sel` and `wr_data` carry.
- R5: With `wr_en` high and `wr_sel` nonzero, the selected register holds `wr_data` from the cycle after the clock edge.
- R6: While `src_a_en` is high, `src_a_vld` is 1 and `src_a_data` shows the register picked by `src_a_sel`. While it is low, `src_a_vld` is 0 and `src_a_data` is all zeros.
- R7: Port B follows the same rule as R6, using `src_b_en`, `src_b_sel`, `src_b_vld` and `src_b_data`.
- R8: Both read ports may select the same register in the same cycle, and both return its value.
- R9: A read of the register being written in the same cycle returns the value it held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| src_a_sel | input | 3 | Register index for read port A |
| src_a_en | input | 1 | Drive enable for read port A |
| src_b_sel | input | 3 | Register index for read port B |
| src_b_en | input | 1 | Drive enable for read port B |
| wr_sel | input | 3 | Destination register index; 0 selects nothing |
| wr_en | input | 1 | Write enable for the result bus |
| wr_data | input | 32 | Result bus data |
| src_a_data | output | 32 | Read port A value; zero when disabled |
| src_a_vld | output | 1 | Read port A is driven |
| src_b_data | output | 32 | Read port B value; zero when disabled |
| src_b_vld | output | 1 | Read port B is driven |

## Verification
The assertions assume that every selector and enable input is a known 0 or 1 from reset onward. They also assume that `wr_data` is stable around the clock edge, because the write-landing check compares the register against the data sampled one edge earlier. The bench changes every input only on the falling clock edge and starts each cycle from a fully defined set of values, so these assumptions always hold. Selector values cover all eight indices, including index 0 on the write port. Disabled write cycles carry live-looking selectors and data, so the check for R4 tests something real.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
   localparam int unsigned GPR_DATA_W_DEF = 32;
   localparam int unsigned GPR_COUNT_DEF  = 8;

   // Outcome of a decoder variant: whether slot zero may ever be loaded
   typedef enum logic {
      SLOT0_WRITABLE  = 1'b0,
      SLOT0_PROTECTED = 1'b1
   } slot0_mode_e;
endpackage

// File: rtl/gpr_wr_decoder.sv
module gpr_wr_decoder #(
   parameter int unsigned         NUM_REGS = gpr_pkg::GPR_COUNT_DEF,
   parameter int unsigned         SEL_W    = $clog2(NUM_REGS),
   parameter gpr_pkg::slot0_mode_e MODE    = gpr_pkg::SLOT0_PROTECTED
) (
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   output logic [NUM_REGS-1:0] wr_strobe
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
      if (g == 0 && MODE == gpr_pkg::SLOT0_PROTECTED) begin : g_open
         // output zero of the decoder is left unconnected to storage
         assign wr_strobe[g] = 1'b0;
      end else begin : g_line
         assign wr_strobe[g] = wr_en && (wr_sel == SEL_W'(g));
      end
   end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
   parameter int unsigned DATA_W   = gpr_pkg::GPR_DATA_W_DEF,
   parameter int unsigned NUM_REGS = gpr_pkg::GPR_COUNT_DEF,
   parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [SEL_W-1:0]                sel,
   input  logic                            en,
   output logic [DATA_W-1:0]               data,
   output logic                            vld
);
   logic [DATA_W-1:0] picked;

   always_comb begin
      picked = regs[sel];
   end

   assign data = en ? picked : '0;
   assign vld  = en;
endmodule

// File: rtl/regfile_dual_read.sv
module regfile_dual_read #(
   parameter int unsigned         DATA_W   = gpr_pkg::GPR_DATA_W_DEF,
   parameter int unsigned         NUM_REGS = gpr_pkg::GPR_COUNT_DEF,
   parameter gpr_pkg::slot0_mode_e MODE    = gpr_pkg::SLOT0_PROTECTED
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(NUM_REGS)-1:0] src_a_sel,
   input  logic                        src_a_en,
   input  logic [$clog2(NUM_REGS)-1:0] src_b_sel,
   input  logic                        src_b_en,
   input  logic [$clog2(NUM_REGS)-1:0] wr_sel,
   input  logic                        wr_en,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [DATA_W-1:0]           src_a_data,
   output logic                        src_a_vld,
   output logic [DATA_W-1:0]           src_b_data,
   output logic                        src_b_vld
);
   localparam int unsigned SEL_W = $clog2(NUM_REGS);

   // elaboration-time parameter checks
   if (NUM_REGS < 2) begin : g_chk_cnt
      $error("regfile_dual_read: NUM_REGS must be at least 2");
   end
   if (NUM_REGS != (1 << SEL_W)) begin : g_chk_pow2
      $error("regfile_dual_read: NUM_REGS must be a power of two");
   end
   if (DATA_W < 1) begin : g_chk_w
      $error("regfile_dual_read: DATA_W must be positive");
   end

   logic [NUM_REGS-1:0]             wr_strobe;
   logic [NUM_REGS-1:0][DATA_W-1:0] gpr_q;

   gpr_wr_decoder #(
      .NUM_REGS(NUM_REGS),
      .SEL_W   (SEL_W),
      .MODE    (MODE)
   ) u_dec (
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_strobe(wr_strobe)
   );

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gpr_q[g] <= '0;
         end else if (wr_strobe[g]) begin
            gpr_q[g] <= wr_data;
         end
      end
   end

   gpr_read_port #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .SEL_W   (SEL_W)
   ) u_port_a (
      .regs(gpr_q),
      .sel (src_a_sel),
      .en  (src_a_en),
      .data(src_a_data),
      .vld (src_a_vld)
   );

   gpr_read_port #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .SEL_W   (SEL_W)
   ) u_port_b (
      .regs(gpr_q),
      .sel (src_b_sel),
      .en  (src_b_en),
      .data(src_b_data),
      .vld (src_b_vld)
   );
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned SEL_W    = 3,
   parameter bit          PROT0    = 1'b1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [SEL_W-1:0]                src_a_sel,
   input logic                            src_a_en,
   input logic [SEL_W-1:0]                src_b_sel,
   input logic                            src_b_en,
   input logic [SEL_W-1:0]                wr_sel,
   input logic                            wr_en,
   input logic [DATA_W-1:0]               wr_data,
   input logic [DATA_W-1:0]               src_a_data,
   input logic                            src_a_vld,
   input logic [DATA_W-1:0]               src_b_data,
   input logic                            src_b_vld,
   input logic [NUM_REGS-1:0]             wr_strobe,
   input logic [NUM_REGS-1:0][DATA_W-1:0] gpr_q
);
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_strobe)); // R3

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_strobe == '0)); // R4

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(gpr_q)); // R4

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != '0) |=> (gpr_q[$past(wr_sel)] == $past(wr_data))); // R5

   AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (PROT0 && src_a_en && src_a_sel == '0) |-> (src_a_data == '0)); // R2

   AST_A_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !src_a_en |-> (!src_a_vld && src_a_data == '0)); // R6

   AST_A_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      src_a_en |-> (src_a_vld && src_a_data == gpr_q[src_a_sel])); // R6

   AST_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !src_b_en |-> (!src_b_vld && src_b_data == '0)); // R7

   AST_SAME_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (src_a_en && src_b_en && src_a_sel == src_b_sel) |-> (src_a_data == src_b_data)); // R8
endmodule

bind regfile_dual_read gpr_checker #(
   .DATA_W  (DATA_W),
   .NUM_REGS(NUM_REGS),
   .SEL_W   (SEL_W),
   .PROT0   (MODE == gpr_pkg::SLOT0_PROTECTED)
) u_gpr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_a_sel (src_a_sel),
   .src_a_en  (src_a_en),
   .src_b_sel (src_b_sel),
   .src_b_en  (src_b_en),
   .wr_sel    (wr_sel),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .src_a_data(src_a_data),
   .src_a_vld (src_a_vld),
   .src_b_data(src_b_data),
   .src_b_vld (src_b_vld),
   .wr_strobe (wr_strobe),
   .gpr_q     (gpr_q)
);

// File: tb/test_regfile_dual_read.sv
module test_regfile_dual_read;
   localparam int DW = 32;

   typedef struct {
      bit          port_b;
      logic [31:0] exp_data;
      logic        exp_vld;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  src_a_sel = '0, src_b_sel = '0, wr_sel = '0;
   logic        src_a_en = 1'b0, src_b_en = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] src_a_data, src_b_data;
   logic        src_a_vld, src_b_vld;

   item_t       sb_q[$];
   logic [31:0] mdl [8];
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   regfile_dual_read i_regfile_dual_read (
      .clk(clk), .rst_n(rst_n),
      .src_a_sel(src_a_sel), .src_a_en(src_a_en),
      .src_b_sel(src_b_sel), .src_b_en(src_b_en),
      .wr_sel(wr_sel), .wr_en(wr_en), .wr_data(wr_data),
      .src_a_data(src_a_data), .src_a_vld(src_a_vld),
      .src_b_data(src_b_data), .src_b_vld(src_b_vld)
   );

   // Driver: one cycle of stimulus, expected read results pushed from the model
   task automatic cyc(input logic [2:0] as, input logic ae,
                      input logic [2:0] bs, input logic be,
                      input logic [2:0] ws, input logic we, input logic [31:0] wd,
                      input string tag);
      item_t it;
      @(negedge clk);
      src_a_sel = as; src_a_en = ae;
      src_b_sel = bs; src_b_en = be;
      wr_sel = ws; wr_en = we; wr_data = wd;
      it.port_b = 1'b0; it.exp_vld = ae; it.exp_data = ae ? mdl[as] : '0; it.tag = tag;
      sb_q.push_back(it);
      it.port_b = 1'b1; it.exp_vld = be; it.exp_data = be ? mdl[bs] : '0; it.tag = tag;
      sb_q.push_back(it);
      // model update takes effect after the coming edge (R9: reads see old value)
      if (we && ws != 3'd0) mdl[ws] = wd;
   endtask

   // Monitor: compares a quarter period after inputs change
   initial begin
      forever begin
         @(negedge clk);
         #5;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] d;
            logic        v;
            it = sb_q.pop_front();
            d = it.port_b ? src_b_data : src_a_data;
            v = it.port_b ? src_b_vld  : src_a_vld;
            checks++;
            if (d !== it.exp_data || v !== it.exp_vld) begin
               failures++;
               $display("FAIL %s port %s: data=%h vld=%b expected data=%h vld=%b",
                        it.tag, it.port_b ? "B" : "A", d, v, it.exp_data, it.exp_vld);
            end
         end
      end
   end

   initial begin
      #3000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state visible on both ports
      for (int i = 0; i < 8; i++) cyc(3'(i), 1'b1, 3'(7 - i), 1'b1, 3'd0, 1'b0, '0, "R1");
      // R5 / R3: load distinct patterns, then read every register back
      for (int i = 1; i < 8; i++)
         cyc(3'd0, 1'b0, 3'd0, 1'b0, 3'(i), 1'b1, 32'hA5000000 ^ (32'(i) * 32'h01010101), "R5");
      for (int i = 0; i < 8; i++) cyc(3'(i), 1'b1, 3'(i ^ 3), 1'b1, 3'd0, 1'b0, '0, "R3");
      // R3: overwrite one register, neighbours unchanged
      cyc(3'd0, 1'b0, 3'd0, 1'b0, 3'd4, 1'b1, 32'hDEADBEEF, "R3");
      for (int i = 0; i < 8; i++) cyc(3'(i), 1'b1, 3'd4, 1'b1, 3'd0, 1'b0, '0, "R3");
      // R2: write aimed at register 0 is dropped
      cyc(3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 32'hFFFFFFFF, "R2");
      cyc(3'd0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b0, '0, "R2");
      // R4: disabled write with live selector and data
      cyc(3'd0, 1'b0, 3'd0, 1'b0, 3'd6, 1'b0, 32'h12345678, "R4");
      cyc(3'd6, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, '0, "R4");
      // R6 / R7: disabled ports read zero with valid low, mixed enables
      cyc(3'd5, 1'b0, 3'd5, 1'b1, 3'd0, 1'b0, '0, "R6");
      cyc(3'd7, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, '0, "R7");
      // R8: both ports on the same register
      for (int i = 1; i < 8; i++) cyc(3'(i), 1'b1, 3'(i), 1'b1, 3'd0, 1'b0, '0, "R8");
      // R9: read while writing the same register returns old value, new next cycle
      cyc(3'd2, 1'b1, 3'd2, 1'b1, 3'd2, 1'b1, 32'h0BADF00D, "R9");
      cyc(3'd2, 1'b1, 3'd2, 1'b1, 3'd0, 1'b0, '0, "R9");
      // R5: back-to-back writes to different registers
      cyc(3'd0, 1'b0, 3'd0, 1'b0, 3'd7, 1'b1, 32'h00000001, "R5");
      cyc(3'd7, 1'b1, 3'd1, 1'b1, 3'd1, 1'b1, 32'h80000000, "R5");
      cyc(3'd7, 1'b1, 3'd1, 1'b1, 3'd0, 1'b0, '0, "R5");
      @(negedge clk);
      wr_en = 1'b0; src_a_en = 1'b0; src_b_en = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule